// File: doc/BRIEF.md
# Shared-Bus AES-128 Round-Key Generator

This block takes an AES-128 cipher key in over the same 32-bit word bus that normally carries ciphertext. A select input decides, cycle by cycle, which way a valid bus word goes. With the select high the word is taken as key material. With it low the word passes straight to the data path. Four key words taken on consecutive valid cycles form the cipher key, with the first word in the most significant position.

Once the fourth word arrives, an iterative expander makes one round key per clock and writes it into an eleven-entry internal store. The entries are prepared for the equivalent inverse cipher. Entry 0 holds the cipher key and entry 10 holds the last round key, both as they are. Entries 1 to 9 hold their round keys after the inverse column mixing. A ready flag tells the decryption rounds when the set is complete. The store has a combinational read port that exists only for those rounds. While the set is incomplete or being replaced, that port returns zero. No key word ever appears on the data-path output.

Top module: `key_sched_mux`

## Requirements
- R1: When `bus_valid` and `key_sel` are both high, the word is key material: `dp_valid` is low and `dp_word` is zero. Four such words on consecutive valid cycles form the key, the first word being bits 127:96.
- R2: When `key_sel` is low, `dp_valid` equals `bus_valid` and `dp_word` equals `bus_word` in the same cycle.
- R3: Entry 0 holds the cipher key unmodified, and entry 10 holds round key 10 unmodified.
- R4: Round key i (1 to 10) has the form w0 = p0 ^ SubWord(RotWord(p3)) ^ {rc_i,24'h0}, w1 = p1 ^ w0, w2 = p2 ^ w1, w3 = p3 ^ w2. Here p is round key i-1 with p0 in bits 127:96, RotWord moves the top byte to the bottom, and rc_i runs 01,02,04,08,10,20,40,80,1B,36.
- R5: Entries 1 to 9 hold their round keys after InvMixColumns, applied to each 32-bit column with the byte in bits 31:24 as row 0.
- R6: `key_ready` rises at the tenth rising edge after the edge that captures the fourth key word, and stays low before that edge.
- R7: The edge that captures the first word of a new load clears `key_ready` and cancels any expansion still running.
- R8: Dropping `key_sel` before the fourth word abandons the load: the word count restarts, no expansion starts, and `key_ready` stays low.
- R9: `rd_key` is zero while `key_ready` is low and for an index above 10. Otherwise it shows entry `rd_idx` in the same cycle.
- R10: After reset `key_ready` is low, `rd_key` reads zero and the word count is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| key_sel | input | 1 | Routes valid bus words to key capture when high |
| bus_valid | input | 1 | Bus word valid |
| bus_word | input | 32 | Shared key / ciphertext word |
| dp_valid | output | 1 | Data-path word valid |
| dp_word | output | 32 | Data-path word, zero during key load |
| key_ready | output | 1 | All eleven entries stored |
| rd_idx | input | 4 | Internal round-key read index |
| rd_key | output | 128 | Internal round-key read data |

## Verification
The assertions take for granted that `key_sel` changes only between edges and that a load is driven as an unbroken run of valid words. Under that assumption, a drop of `key_ready` can be traced to a captured key word. They also take for granted that `rd_idx` is held steady across a read. The stimulus drives every bus and index change at the falling edge. It sends each key as four back-to-back valid words, and it breaks a load only deliberately, by lowering `key_sel`. It compares stored entries against published expansions of two keys and of the all-zero key.

// File: rtl/ks_pkg.sv
package ks_pkg;

  function automatic logic [7:0] gf_mul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] acc;
    logic [7:0] sh;
    acc = 8'h00;
    sh  = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) acc = acc ^ sh;
      sh = {sh[6:0], 1'b0} ^ (sh[7] ? 8'h1b : 8'h00);
    end
    return acc;
  endfunction

  function automatic logic [7:0] xtime(input logic [7:0] a);
    return {a[6:0], 1'b0} ^ (a[7] ? 8'h1b : 8'h00);
  endfunction

  // forward substitution: inverse by a^254, then the affine step
  function automatic logic [7:0] fwd_sub(input logic [7:0] a);
    logic [7:0] r;
    logic [7:0] base;
    logic [7:0] e;
    r    = 8'h01;
    base = a;
    e    = 8'd254;
    for (int i = 0; i < 8; i++) begin
      if (e[i]) r = gf_mul(r, base);
      base = gf_mul(base, base);
    end
    return r ^ {r[6:0], r[7]} ^ {r[5:0], r[7:6]} ^ {r[4:0], r[7:5]} ^
           {r[3:0], r[7:4]} ^ 8'h63;
  endfunction

  function automatic logic [31:0] sub_rot(input logic [31:0] w);
    logic [31:0] r;
    r = {w[23:0], w[31:24]};
    return {fwd_sub(r[31:24]), fwd_sub(r[23:16]), fwd_sub(r[15:8]), fwd_sub(r[7:0])};
  endfunction

  function automatic logic [31:0] unmix_col(input logic [31:0] c);
    logic [7:0] a0, a1, a2, a3;
    a0 = c[31:24]; a1 = c[23:16]; a2 = c[15:8]; a3 = c[7:0];
    return {
      gf_mul(a0, 8'h0e) ^ gf_mul(a1, 8'h0b) ^ gf_mul(a2, 8'h0d) ^ gf_mul(a3, 8'h09),
      gf_mul(a0, 8'h09) ^ gf_mul(a1, 8'h0e) ^ gf_mul(a2, 8'h0b) ^ gf_mul(a3, 8'h0d),
      gf_mul(a0, 8'h0d) ^ gf_mul(a1, 8'h09) ^ gf_mul(a2, 8'h0e) ^ gf_mul(a3, 8'h0b),
      gf_mul(a0, 8'h0b) ^ gf_mul(a1, 8'h0d) ^ gf_mul(a2, 8'h09) ^ gf_mul(a3, 8'h0e)};
  endfunction

  typedef enum logic {EXP_IDLE, EXP_RUN} exp_state_t;

endpackage

// File: rtl/ks_capture.sv
module ks_capture #(
  parameter int WORD_W    = 32,
  parameter int KEY_WORDS = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        key_sel,
  input  logic                        bus_valid,
  input  logic [WORD_W-1:0]           bus_word,
  output logic                        load_first,
  output logic                        load_done,
  output logic [WORD_W*KEY_WORDS-1:0] key_full
);
  localparam int KEY_W = WORD_W * KEY_WORDS;
  localparam int CNT_W = (KEY_WORDS > 1) ? $clog2(KEY_WORDS) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(KEY_WORDS - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [KEY_W-1:0] sh_q, sh_d;
  logic             take;

  assign take       = bus_valid & key_sel;
  assign load_first = take & (cnt_q == '0);
  assign load_done  = take & (cnt_q == LAST);

  generate
    if (KEY_WORDS > 1) begin : g_multi
      assign key_full = {sh_q[KEY_W-WORD_W-1:0], bus_word};
      assign sh_d     = take ? {sh_q[KEY_W-WORD_W-1:0], bus_word} : sh_q;
    end else begin : g_single
      assign key_full = bus_word;
      assign sh_d     = take ? bus_word : sh_q;
    end
  endgenerate

  always_comb begin
    cnt_d = cnt_q;
    if (!key_sel)      cnt_d = '0;
    else if (load_done) cnt_d = '0;
    else if (take)     cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  always_ff @(posedge clk) begin
    if (take) sh_q <= sh_d;
  end
endmodule

// File: rtl/ks_expand.sv
module ks_expand
  import ks_pkg::*;
#(
  parameter int NUM_ROUNDS = 10,
  parameter int KEY_W      = 128,
  parameter int IDX_W      = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             abort,
  input  logic [KEY_W-1:0] key_in,
  output logic             wr_en,
  output logic [IDX_W-1:0] wr_idx,
  output logic [KEY_W-1:0] wr_data,
  output logic             busy,
  output logic             done
);
  localparam int COLS = KEY_W / 32;
  localparam logic [IDX_W-1:0] LAST_RND = IDX_W'(NUM_ROUNDS);

  exp_state_t       st_q, st_d;
  logic [IDX_W-1:0] rnd_q, rnd_d;
  logic [7:0]       rc_q, rc_d;
  logic [KEY_W-1:0] work_q, work_d;
  logic [KEY_W-1:0] nxt;
  logic [KEY_W-1:0] nxt_unmixed;

  // next round key, column by column
  always_comb begin
    logic [31:0] prev;
    prev = work_q[31:0] ^ 32'h0;
    nxt = '0;
    prev = work_q[KEY_W-1 -: 32] ^ sub_rot(work_q[31:0]) ^ {rc_q, 24'h0};
    nxt[KEY_W-1 -: 32] = prev;
    for (int c = 1; c < COLS; c++) begin
      prev = work_q[KEY_W-1-32*c -: 32] ^ prev;
      nxt[KEY_W-1-32*c -: 32] = prev;
    end
  end

  genvar gc;
  generate
    for (gc = 0; gc < COLS; gc++) begin : g_unmix
      assign nxt_unmixed[KEY_W-1-32*gc -: 32] = unmix_col(nxt[KEY_W-1-32*gc -: 32]);
    end
  endgenerate

  always_comb begin
    st_d    = st_q;
    rnd_d   = rnd_q;
    rc_d    = rc_q;
    work_d  = work_q;
    wr_en   = 1'b0;
    wr_idx  = '0;
    wr_data = key_in;
    done    = 1'b0;
    if (start) begin
      st_d   = EXP_RUN;
      rnd_d  = IDX_W'(1);
      rc_d   = 8'h01;
      work_d = key_in;
      wr_en  = 1'b1;
    end else if (abort) begin
      st_d = EXP_IDLE;
    end else if (st_q == EXP_RUN) begin
      wr_en   = 1'b1;
      wr_idx  = rnd_q;
      wr_data = (rnd_q == LAST_RND) ? nxt : nxt_unmixed;
      work_d  = nxt;
      rc_d    = xtime(rc_q);
      if (rnd_q == LAST_RND) begin
        st_d = EXP_IDLE;
        done = 1'b1;
      end else begin
        rnd_d = rnd_q + 1'b1;
      end
    end
  end

  assign busy = (st_q == EXP_RUN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= EXP_IDLE;
      rnd_q <= '0;
      rc_q  <= 8'h01;
    end else begin
      st_q  <= st_d;
      rnd_q <= rnd_d;
      rc_q  <= rc_d;
    end
  end

  always_ff @(posedge clk) begin
    if (start || st_q == EXP_RUN) work_q <= work_d;
  end
endmodule

// File: rtl/ks_store.sv
module ks_store #(
  parameter int ENTRIES = 11,
  parameter int KEY_W   = 128,
  parameter int IDX_W   = 4
) (
  input  logic             clk,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [KEY_W-1:0] wr_data,
  input  logic             rd_open,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [KEY_W-1:0] rd_data
);
  logic [KEY_W-1:0] mem [ENTRIES];

  genvar ge;
  generate
    for (ge = 0; ge < ENTRIES; ge++) begin : g_ent
      always_ff @(posedge clk) begin
        if (wr_en && wr_idx == IDX_W'(ge)) mem[ge] <= wr_data;
      end
    end
  endgenerate

  always_comb begin
    rd_data = '0;
    for (int e = 0; e < ENTRIES; e++) begin
      if (rd_open && rd_idx == IDX_W'(e)) rd_data = mem[e];
    end
  end
endmodule

// File: rtl/key_sched_mux.sv
module key_sched_mux #(
  parameter int WORD_W     = 32,
  parameter int KEY_WORDS  = 4,
  parameter int NUM_ROUNDS = 10,
  localparam int KEY_W     = WORD_W * KEY_WORDS,
  localparam int ENTRIES   = NUM_ROUNDS + 1,
  localparam int IDX_W     = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              key_sel,
  input  logic              bus_valid,
  input  logic [WORD_W-1:0] bus_word,
  output logic              dp_valid,
  output logic [WORD_W-1:0] dp_word,
  output logic              key_ready,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [KEY_W-1:0]  rd_key
);
  logic             load_first, load_done;
  logic [KEY_W-1:0] key_full;
  logic             wr_en, exp_busy, exp_done;
  logic [IDX_W-1:0] wr_idx;
  logic [KEY_W-1:0] wr_data;
  logic             ready_d;

  assign dp_valid = bus_valid & ~key_sel;
  assign dp_word  = key_sel ? '0 : bus_word;

  ks_capture #(.WORD_W(WORD_W), .KEY_WORDS(KEY_WORDS)) u_cap (
    .clk(clk), .rst_n(rst_n), .key_sel(key_sel), .bus_valid(bus_valid),
    .bus_word(bus_word), .load_first(load_first), .load_done(load_done),
    .key_full(key_full));

  ks_expand #(.NUM_ROUNDS(NUM_ROUNDS), .KEY_W(KEY_W), .IDX_W(IDX_W)) u_exp (
    .clk(clk), .rst_n(rst_n), .start(load_done), .abort(load_first),
    .key_in(key_full), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .busy(exp_busy), .done(exp_done));

  ks_store #(.ENTRIES(ENTRIES), .KEY_W(KEY_W), .IDX_W(IDX_W)) u_mem (
    .clk(clk), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .rd_open(key_ready), .rd_idx(rd_idx), .rd_data(rd_key));

  always_comb begin
    ready_d = key_ready;
    if (load_first)    ready_d = 1'b0;
    else if (exp_done) ready_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) key_ready <= 1'b0;
    else        key_ready <= ready_d;
  end
endmodule

// File: rtl/ks_checker.sv
module ks_checker #(
  parameter int KEY_W = 128,
  parameter int IDX_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             key_sel,
  input logic             bus_valid,
  input logic             dp_valid,
  input logic             key_ready,
  input logic             busy,
  input logic [IDX_W-1:0] rd_idx,
  input logic [KEY_W-1:0] rd_key
);
  // R1: key words never reach the data path
  a_r1_no_key_on_dp: assert property (@(posedge clk) disable iff (!rst_n)
    key_sel |-> !dp_valid);

  // R7: ready only falls after a captured key word
  a_r7_fall_on_load: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(key_ready) |-> $past(bus_valid && key_sel));

  // R6: never ready while expansion is running
  a_r6_busy_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !key_ready);

  // R9: read port closed while not ready
  a_r9_closed_read: assert property (@(posedge clk) disable iff (!rst_n)
    !key_ready |-> rd_key == '0);

  // R3: a complete set does not change under a steady index
  a_r3_stable_set: assert property (@(posedge clk) disable iff (!rst_n)
    (key_ready && $past(key_ready) && $stable(rd_idx)) |-> $stable(rd_key));
endmodule

bind key_sched_mux ks_checker #(.KEY_W(KEY_W), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .key_sel(key_sel), .bus_valid(bus_valid),
  .dp_valid(dp_valid), .key_ready(key_ready), .busy(exp_busy),
  .rd_idx(rd_idx), .rd_key(rd_key));

// File: tb/key_sched_mux_test.sv
`timescale 1ns/1ps
module key_sched_mux_test;
  logic         clk = 1'b0;
  logic         rst_n;
  logic         key_sel;
  logic         bus_valid;
  logic [31:0]  bus_word;
  logic         dp_valid;
  logic [31:0]  dp_word;
  logic         key_ready;
  logic [3:0]   rd_idx;
  logic [127:0] rd_key;

  int checks = 0;
  int errors = 0;

  typedef struct {
    logic [3:0]   idx;
    logic [127:0] val;
    string        req;
  } exp_item_t;
  exp_item_t sb_q[$];

  always #2.5 clk = ~clk;

  key_sched_mux uut (
    .clk(clk), .rst_n(rst_n), .key_sel(key_sel), .bus_valid(bus_valid),
    .bus_word(bus_word), .dp_valid(dp_valid), .dp_word(dp_word),
    .key_ready(key_ready), .rd_idx(rd_idx), .rd_key(rd_key));

  function automatic logic [7:0] mulg(input logic [7:0] a, input logic [7:0] b);
    logic [15:0] p;
    p = '0;
    for (int i = 0; i < 8; i++) if (b[i]) p = p ^ (16'(a) << i);
    for (int i = 15; i >= 8; i--) if (p[i]) p = p ^ (16'h11b << (i - 8));
    return p[7:0];
  endfunction

  function automatic logic [127:0] unmix(input logic [127:0] k);
    logic [127:0] r;
    for (int c = 0; c < 4; c++) begin
      logic [7:0] b0, b1, b2, b3;
      b0 = k[127-32*c -: 8]; b1 = k[119-32*c -: 8];
      b2 = k[111-32*c -: 8]; b3 = k[103-32*c -: 8];
      r[127-32*c -: 8] = mulg(8'h0e,b0)^mulg(8'h0b,b1)^mulg(8'h0d,b2)^mulg(8'h09,b3);
      r[119-32*c -: 8] = mulg(8'h09,b0)^mulg(8'h0e,b1)^mulg(8'h0b,b2)^mulg(8'h0d,b3);
      r[111-32*c -: 8] = mulg(8'h0d,b0)^mulg(8'h09,b1)^mulg(8'h0e,b2)^mulg(8'h0b,b3);
      r[103-32*c -: 8] = mulg(8'h0b,b0)^mulg(8'h0d,b1)^mulg(8'h09,b2)^mulg(8'h0e,b3);
    end
    return r;
  endfunction

  task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic push(input logic [3:0] idx, input logic [127:0] val, input string req);
    exp_item_t it;
    it.idx = idx; it.val = val; it.req = req;
    sb_q.push_back(it);
  endtask

  // drive one key word at the falling edge; check routing
  task automatic send_key_word(input logic [31:0] w);
    @(negedge clk);
    key_sel = 1'b1; bus_valid = 1'b1; bus_word = w;
    #1;
    check("R1 dp_valid during key load", 128'(dp_valid), 128'd0);
    check("R1 dp_word during key load", 128'(dp_word), 128'd0);
  endtask

  // load a full key and check the ready timing
  task automatic load_key(input logic [127:0] k);
    send_key_word(k[127:96]);
    send_key_word(k[95:64]);
    send_key_word(k[63:32]);
    send_key_word(k[31:0]);
    @(posedge clk);
    #1;
    key_sel = 1'b0; bus_valid = 1'b0; bus_word = '0;
    for (int i = 1; i < 10; i++) begin
      @(posedge clk);
      #1;
      if (i == 1 || i == 9) check("R6 ready low during expansion", 128'(key_ready), 128'd0);
    end
    @(posedge clk);
    #1;
    check("R6 ready at tenth edge", 128'(key_ready), 128'd1);
  endtask

  task automatic drain();
    wait (sb_q.size() == 0);
    @(negedge clk);
    @(negedge clk);
  endtask

  // monitor: pops expected entries and reads them through the internal port
  initial begin
    exp_item_t it;
    forever begin
      wait (sb_q.size() > 0);
      it = sb_q[0];
      @(negedge clk);
      rd_idx = it.idx;
      #1;
      check(it.req, rd_key, it.val);
      void'(sb_q.pop_front());
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [127:0] ka [11];
    ka[0]  = 128'h000102030405060708090a0b0c0d0e0f;
    ka[1]  = 128'hd6aa74fdd2af72fadaa678f1d6ab76fe;
    ka[2]  = 128'hb692cf0b643dbdf1be9bc5006830b3fe;
    ka[3]  = 128'hb6ff744ed2c2c9bf6c590cbf0469bf41;
    ka[4]  = 128'h47f7f7bc95353e03f96c32bcfd058dfd;
    ka[5]  = 128'h3caaa3e8a99f9deb50f3af57adf622aa;
    ka[6]  = 128'h5e390f7df7a69296a7553dc10aa31f6b;
    ka[7]  = 128'h14f9701ae35fe28c440adf4d4ea9c026;
    ka[8]  = 128'h47438735a41c65b9e016baf4aebf7ad2;
    ka[9]  = 128'h549932d1f08557681093ed9cbe2c974e;
    ka[10] = 128'h13111d7fe3944a17f307a78b4d2b30c5;

    rst_n = 1'b0; key_sel = 1'b0; bus_valid = 1'b0; bus_word = '0; rd_idx = '0;
    repeat (3) @(posedge clk);
    #1;
    check("R10 ready after reset", 128'(key_ready), 128'd0);
    check("R10 read closed after reset", rd_key, 128'd0);
    @(negedge clk);
    rst_n = 1'b1;

    // R2 pass-through
    @(negedge clk);
    bus_valid = 1'b1; bus_word = 32'hcafe0123;
    #1;
    check("R2 dp_valid pass", 128'(dp_valid), 128'd1);
    check("R2 dp_word pass", 128'(dp_word), 128'(32'hcafe0123));
    @(negedge clk);
    bus_valid = 1'b0;
    #1;
    check("R2 dp_valid idle", 128'(dp_valid), 128'd0);

    // R8 abandoned load: two words then key_sel drops
    send_key_word(32'h11111111);
    send_key_word(32'h22222222);
    @(negedge clk);
    key_sel = 1'b0; bus_valid = 1'b0;
    repeat (15) @(posedge clk);
    #1;
    check("R8 no ready after abandoned load", 128'(key_ready), 128'd0);
    check("R9 read closed when not ready", rd_key, 128'd0);

    // main load; count restarts so these four words form the key
    load_key(ka[0]);
    push(4'd0, ka[0], "R3 entry 0 is cipher key");
    for (int i = 1; i < 10; i++) push(4'(i), unmix(ka[i]), "R5 unmixed middle entry");
    push(4'd10, ka[10], "R3 entry 10 unmodified");
    push(4'd11, 128'd0, "R9 index above 10 reads zero");
    push(4'd15, 128'd0, "R9 index 15 reads zero");
    drain();

    // R7: first word of a new load clears ready
    send_key_word(32'h2b7e1516);
    @(posedge clk);
    #1;
    check("R7 ready cleared by first word", 128'(key_ready), 128'd0);
    check("R9 read closed during reload", rd_key, 128'd0);
    @(negedge clk);
    key_sel = 1'b0; bus_valid = 1'b0;

    // second key (R4 via known expansion)
    load_key(128'h2b7e151628aed2a6abf7158809cf4f3c);
    push(4'd0, 128'h2b7e151628aed2a6abf7158809cf4f3c, "R3 entry 0 second key");
    push(4'd1, unmix(128'ha0fafe1788542cb123a339392a6c7605), "R4 round 1 second key");
    push(4'd10, 128'hd014f9a8c9ee2589e13f0cc8b6630ca6, "R4 round 10 second key");
    drain();

    // all-zero key, reloaded while a previous set is ready
    load_key(128'd0);
    push(4'd1, unmix(128'h62636363626363636263636362636363), "R4 round 1 zero key");
    push(4'd2, unmix(128'h9b9898c9f9fbfbaa9b9898c9f9fbfbaa), "R4 round 2 zero key");
    push(4'd10, 128'hb4ef5bcb3e92e21123e951cf6f8f188e, "R4 round 10 zero key");
    drain();

    // R7: new load cancels a running expansion; full reload still correct
    send_key_word(32'h0);
    send_key_word(32'h0);
    send_key_word(32'h0);
    send_key_word(32'h0);
    @(negedge clk);
    key_sel = 1'b0; bus_valid = 1'b0;
    repeat (3) @(posedge clk);
    load_key(ka[0]);
    push(4'd10, ka[10], "R7 reload after cancelled expansion");
    push(4'd5, unmix(ka[5]), "R5 entry 5 after reload");
    drain();

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule